// File: doc/BRIEF.md
# PLL Output Channel Divider

This block sits behind one PLL output and turns it into a slower clock for a downstream consumer. It runs on the PLL output clock itself and counts cycles of that clock. It produces a registered divided clock `ch_clk` and a one-cycle pulse `ch_tick` that marks the start of each output period. The channel has its own 32-bit control register. That register holds an 8-bit divide field in bits [7:0] and a channel-off bit at bit 12. Software loads it through a plain write strobe. Reset loads a per-instance default value.

The parent PLL's shared control word arrives as an input, and one bit of it (bit 4 by default) holds every channel of that PLL. A third input tells the channel whether the parent PLL is producing a clock at all. When any of these three conditions stops the channel, the output is parked low and no ticks are issued. A downstream consumer never sees a slowed clock, only no clock.

The total division is the effective divide value times a fixed post-divide factor of 1 or 2, chosen per instance. A divide field of zero selects 255. A new divisor is picked up only at an output period boundary, so each period runs whole.

Top module: `pll_chan_div`

## Requirements
- R1: While `rst_n` is low, `ch_clk` and `ch_tick` are 0. After reset the control register holds `RST_CTRL` (default divide 4, channel on), so with the default settings the channel runs with a period of 4 × `FIXED_DIV` cycles.
- R2: While running, consecutive `ch_tick` pulses are exactly P cycles apart, where P = effective divide × `FIXED_DIV`, and the internal phase count stays below P.
- R3: In each period, `ch_clk` is high for the first ceil(P/2) cycles, starting in the tick cycle, and low for the rest. For P = 1, `ch_clk` stays high and `ch_tick` fires every cycle.
- R4: A divide field (control bits [7:0]) of zero acts as a divisor of 255.
- R5: With `FIXED_DIV` = 2, every period is twice as long as with `FIXED_DIV` = 1 for the same divide field, and the high phase is half of that period.
- R6: When control bit 12 is 1, `ch_clk` is 0 and no ticks occur from the second clock edge after the write onward.
- R7: When bit `HOLD_BIT` (default 4) of `pll_ctrl` is 1, `ch_clk` and `ch_tick` are 0 from the next clock edge. All other `pll_ctrl` bits have no effect on the output.
- R8: When `pll_live` is 0, `ch_clk` and `ch_tick` are 0 from the next clock edge.
- R9: A divisor written in the middle of a period does not alter that period. It applies from the next period boundary.
- R10: When a stop condition clears, the first clock edge starts a fresh period with a tick and a high output.
- R11: `chan_wdata` is loaded into the control register only at edges where `chan_wr` is 1. With `chan_wr` at 0, a changed `chan_wdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock that the channel divides |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_live | input | 1 | 1 when the parent PLL is producing a clock |
| pll_ctrl | input | 32 | Parent PLL shared control word; bit HOLD_BIT holds the channel |
| chan_wr | input | 1 | Write strobe for the channel control register |
| chan_wdata | input | 32 | Value loaded into the channel control register |
| ch_clk | output | 1 | Divided output clock, low while stopped |
| ch_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The divide field is swept through a table of values: the smallest divisor (1), even and odd divisors, the largest field value, and the zero encoding. Odd against even separates the rounding of the high phase. Zero against 255 confirms the zero encoding maps to the maximum divisor rather than to a bypass. Two instances that differ only in their fixed post-divide factor receive the same stimulus, which isolates the doubling. Directed sequences then apply each of the three stop conditions, toggle unrelated shared-register bits, and rewrite the divisor just after a tick. The mid-period rewrite shows that the running period completes before the new divisor applies.

// File: rtl/pcd_pkg.sv
// Package: shared types and helpers for the PLL channel divider.
// Assumes: parameters are checked by the modules that use them.
package pcd_pkg;

    // Waveform generator state: parked (gated) or counting a period.
    typedef enum logic {
        WS_STOP = 1'b0,
        WS_RUN  = 1'b1
    } wave_state_t;

    // Longest output period, in input cycles, for a divide field width and
    // fixed post-divide factor.
    function automatic int unsigned max_period(input int unsigned div_w,
                                               input int unsigned fixed_div);
        return ((32'd1 << div_w) - 32'd1) * fixed_div;
    endfunction

    // Number of bits needed to hold values 0..n.
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((32'd1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/chan_ctrl_reg.sv
// Module: channel control register.
// Holds the channel's control word, loaded by a write strobe, with a
// per-instance reset value. Decodes the divide field and the off bit.
// Assumes: DIS_BIT lies outside the divide field and inside the word.
module chan_ctrl_reg #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned DIS_BIT  = 12,
    parameter logic [CTRL_W-1:0] RST_CTRL = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [DIV_W-1:0]  div,
    output logic              dis
);

    logic [CTRL_W-1:0] ctrl_q;

    // Load the control word on a write, default value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RST_CTRL;
        end else if (wr) begin
            ctrl_q <= wdata;
        end
    end

    // Field decode.
    assign div = ctrl_q[DIV_W-1:0];
    assign dis = ctrl_q[DIS_BIT];

endmodule

// File: rtl/chan_gate.sv
// Module: run/stop decision for the channel.
// The channel runs only when its own off bit is clear, the hold bit in the
// parent PLL's shared word is clear, and the parent PLL is live. Purely
// combinational, so a change in the shared word reaches every channel of
// that PLL in the same cycle.
// Assumes: HOLD_BIT < CTRL_W.
module chan_gate #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned HOLD_BIT = 4
) (
    input  logic              dis,
    input  logic [CTRL_W-1:0] pll_ctrl,
    input  logic              pll_live,
    output logic              run
);

    logic hold;

    // Pick out this PLL's hold bit.
    assign hold = pll_ctrl[HOLD_BIT];

    // All three conditions must allow the clock.
    always_comb begin
        run = pll_live && !dis && !hold;
    end

endmodule

// File: rtl/chan_period.sv
// Module: period and high-phase computation.
// Maps the divide field to an effective divisor (zero means all ones),
// applies the fixed post-divider, and derives the high-phase length
// ceil(period/2).
// Assumes: FIXED_DIV is 1 or 2; PER_W holds the largest period.
module chan_period #(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned FIXED_DIV = 1,
    parameter int unsigned PER_W     = 8
) (
    input  logic [DIV_W-1:0] div,
    output logic [PER_W-1:0] per,
    output logic [PER_W-1:0] hi
);

    logic [DIV_W-1:0] eff;
    logic [PER_W:0]   per_p1;

    // Zero encodes the largest divisor.
    always_comb begin
        eff = (div == '0) ? {DIV_W{1'b1}} : div;
    end

    // Apply the fixed post-divider.
    generate
        if (FIXED_DIV == 2) begin : g_fixed2
            assign per = PER_W'({eff, 1'b0});
        end else begin : g_fixed1
            assign per = PER_W'(eff);
        end
    endgenerate

    // High phase rounds up for odd periods.
    assign per_p1 = {1'b0, per} + (PER_W + 1)'(1);
    assign hi     = per_p1[PER_W:1];

endmodule

// File: rtl/chan_wave.sv
// Module: divided clock generator.
// Counts input cycles over one output period, drives the output high for
// the first hi cycles, and pulses a tick at each period start. Period and
// high length are sampled only at a period boundary or when starting from
// the stopped state. When run drops, the output parks low at the next edge
// and the count restarts from zero.
// Assumes: per_new >= 1 and hi_new is in 1..per_new.
module chan_wave
    import pcd_pkg::*;
#(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] per_new,
    input  logic [PER_W-1:0] hi_new,
    output logic             ch_clk,
    output logic             ch_tick,
    output logic [PER_W-1:0] per_q,
    output logic [PER_W-1:0] cnt_q
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    wave_state_t      st_q;
    logic [PER_W-1:0] hi_q;
    logic [PER_W-1:0] cnt_nx;
    logic             wrap;
    logic             out_q;
    logic             tick_q;

    // Next count and end-of-period detection.
    always_comb begin
        cnt_nx = cnt_q + ONE;
        wrap   = (cnt_q == per_q - ONE);
    end

    // Period counter, latched divisor and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WS_STOP;
            cnt_q  <= '0;
            per_q  <= ONE;
            hi_q   <= ONE;
            out_q  <= 1'b0;
            tick_q <= 1'b0;
        end else if (!run) begin
            st_q   <= WS_STOP;
            cnt_q  <= '0;
            out_q  <= 1'b0;
            tick_q <= 1'b0;
        end else if (st_q == WS_STOP || wrap) begin
            st_q   <= WS_RUN;
            cnt_q  <= '0;
            per_q  <= per_new;
            hi_q   <= hi_new;
            out_q  <= 1'b1;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_nx;
            out_q  <= (cnt_nx < hi_q);
            tick_q <= 1'b0;
        end
    end

    assign ch_clk  = out_q;
    assign ch_tick = tick_q;

endmodule

// File: rtl/pll_chan_div.sv
// Module: PLL output channel divider (top).
// Divides the PLL output clock by (divide field, zero meaning maximum) times
// a fixed post-divide factor. Gated off by the channel off bit, the parent
// PLL's hold bit, or an absent parent clock.
// Assumes: clk is the parent PLL output; pll_ctrl is synchronous to it.
module pll_chan_div
    import pcd_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIS_BIT   = 12,
    parameter int unsigned HOLD_BIT  = 4,
    parameter int unsigned FIXED_DIV = 1,
    parameter logic [CTRL_W-1:0] RST_CTRL = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_live,
    input  logic [CTRL_W-1:0] pll_ctrl,
    input  logic              chan_wr,
    input  logic [CTRL_W-1:0] chan_wdata,
    output logic              ch_clk,
    output logic              ch_tick
);

    localparam int unsigned MAX_PER = max_period(DIV_W, FIXED_DIV);
    localparam int unsigned PER_W   = bits_for(MAX_PER);

    logic [DIV_W-1:0] div;
    logic             dis;
    logic             run;
    logic [PER_W-1:0] per_new;
    logic [PER_W-1:0] hi_new;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] cnt_q;

    chan_ctrl_reg #(
        .CTRL_W   (CTRL_W),
        .DIV_W    (DIV_W),
        .DIS_BIT  (DIS_BIT),
        .RST_CTRL (RST_CTRL)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (chan_wr),
        .wdata (chan_wdata),
        .div   (div),
        .dis   (dis)
    );

    chan_gate #(
        .CTRL_W   (CTRL_W),
        .HOLD_BIT (HOLD_BIT)
    ) u_gate (
        .dis      (dis),
        .pll_ctrl (pll_ctrl),
        .pll_live (pll_live),
        .run      (run)
    );

    chan_period #(
        .DIV_W     (DIV_W),
        .FIXED_DIV (FIXED_DIV),
        .PER_W     (PER_W)
    ) u_period (
        .div (div),
        .per (per_new),
        .hi  (hi_new)
    );

    chan_wave #(
        .PER_W (PER_W)
    ) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .per_new (per_new),
        .hi_new  (hi_new),
        .ch_clk  (ch_clk),
        .ch_tick (ch_tick),
        .per_q   (per_q),
        .cnt_q   (cnt_q)
    );

endmodule

// File: rtl/pll_chan_div_chk.sv
// Module: assertion checker for pll_chan_div, attached by bind.
// Assumes: connected to the top module's ports and internal nets.
module pll_chan_div_chk #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned HOLD_BIT = 4,
    parameter int unsigned PER_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_live,
    input logic [CTRL_W-1:0] pll_ctrl,
    input logic              dis,
    input logic              ch_clk,
    input logic              ch_tick,
    input logic [PER_W-1:0]  per_q,
    input logic [PER_W-1:0]  cnt_q
);

    // Phase count never reaches the latched period.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_q);

    // A tick always opens a high phase.
    assert_tick_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_tick |-> ch_clk);

    // Channel off bit parks the output.
    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !ch_clk && !ch_tick);

    // Shared hold bit parks the output.
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ctrl[HOLD_BIT] |=> !ch_clk && !ch_tick);

    // Absent parent clock parks the output.
    assert_dead_pll_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_live |=> !ch_clk && !ch_tick);

    // Latched period changes only at a period start.
    assert_latch_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_tick |-> $stable(per_q));

endmodule

bind pll_chan_div pll_chan_div_chk #(
    .CTRL_W   (CTRL_W),
    .HOLD_BIT (HOLD_BIT),
    .PER_W    (PER_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_live (pll_live),
    .pll_ctrl (pll_ctrl),
    .dis      (dis),
    .ch_clk   (ch_clk),
    .ch_tick  (ch_tick),
    .per_q    (per_q),
    .cnt_q    (cnt_q)
);

// File: tb/sim_pll_chan_div.sv
// Bench: u0 uses fixed factor 1, u1 fixed factor 2; both share stimulus.
module sim_pll_chan_div;

    localparam int N_VEC = 7;
    localparam int VEC_DIV [N_VEC] = '{1, 2, 3, 7, 0, 255, 16};
    localparam int VEC_PER [N_VEC] = '{1, 2, 3, 7, 255, 255, 16};
    localparam int VEC_HI  [N_VEC] = '{1, 1, 2, 4, 128, 128, 8};
    localparam logic [31:0] OFF_BIT  = 32'h0000_1000;
    localparam logic [31:0] HOLD_MSK = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pll_live;
    logic [31:0] pll_ctrl;
    logic        chan_wr;
    logic [31:0] chan_wdata;
    logic        c0, t0, c1, t1;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    pll_chan_div u0 (
        .clk (clk), .rst_n (rst_n), .pll_live (pll_live), .pll_ctrl (pll_ctrl),
        .chan_wr (chan_wr), .chan_wdata (chan_wdata), .ch_clk (c0), .ch_tick (t0)
    );

    pll_chan_div #(.FIXED_DIV(2)) u1 (
        .clk (clk), .rst_n (rst_n), .pll_live (pll_live), .pll_ctrl (pll_ctrl),
        .chan_wr (chan_wr), .chan_wdata (chan_wdata), .ch_clk (c1), .ch_tick (t1)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit tk(input bit sel);
        return sel ? t1 : t0;
    endfunction

    function automatic bit ck(input bit sel);
        return sel ? c1 : c0;
    endfunction

    // Skip to the next tick, then count one full period and its high cycles.
    task automatic measure(input bit sel, output int per, output int hi);
        int guard;
        guard = 0;
        per = 0;
        hi = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tk(sel) && guard < 2000);
        do begin
            if (ck(sel)) hi++;
            per++;
            @(negedge clk);
        end while (!tk(sel) && per < 2000);
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk);
        chan_wr = 1'b1;
        chan_wdata = v;
        @(negedge clk);
        chan_wr = 1'b0;
    endtask

    // Count output activity over n cycles.
    task automatic activity(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (c0 || t0 || c1 || t1) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int p, h, a, cnt;
        rst_n = 1'b0;
        pll_live = 1'b1;
        pll_ctrl = '0;
        chan_wr = 1'b0;
        chan_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: quiet during reset
        chk(!c0 && !t0 && !c1 && !t1, "R1 reset outputs low", int'(c0 | t0 | c1 | t1), 0);
        rst_n = 1'b1;
        // R1: default control value divides by 4
        measure(0, p, h);
        chk(p == 4, "R1 default period u0", p, 4);
        measure(1, p, h);
        chk(p == 8, "R1 default period u1", p, 8);

        // R2 R3 R4 R5 R11: vector sweep
        for (int v = 0; v < N_VEC; v++) begin
            wr_ctrl(32'(VEC_DIV[v]));
            measure(0, p, h);
            measure(0, p, h);
            chk(p == VEC_PER[v], $sformatf("R2 R4 R11 period div=%0d", VEC_DIV[v]), p, VEC_PER[v]);
            chk(h == VEC_HI[v], $sformatf("R3 high phase div=%0d", VEC_DIV[v]), h, VEC_HI[v]);
            measure(1, p, h);
            measure(1, p, h);
            chk(p == 2 * VEC_PER[v], $sformatf("R5 fixed2 period div=%0d", VEC_DIV[v]), p, 2 * VEC_PER[v]);
            chk(h == VEC_PER[v], $sformatf("R5 fixed2 high div=%0d", VEC_DIV[v]), h, VEC_PER[v]);
        end

        // R11: data without strobe is ignored
        wr_ctrl(32'd6);
        measure(0, p, h);
        @(negedge clk);
        chan_wdata = 32'd9;
        measure(0, p, h);
        measure(0, p, h);
        chk(p == 6, "R11 no strobe no load", p, 6);

        // R6: channel off bit
        wr_ctrl(OFF_BIT | 32'd2);
        @(negedge clk);
        chk(!c0 && !t0 && !c1 && !t1, "R6 off at second edge", int'(c0 | c1), 0);
        activity(20, a);
        chk(a == 0, "R6 stays off", a, 0);
        wr_ctrl(32'd5);

        // R7: hold bit and other shared bits
        measure(0, p, h);
        pll_ctrl = ~HOLD_MSK;
        measure(0, p, h);
        measure(0, p, h);
        chk(p == 5, "R7 other shared bits ignored", p, 5);
        @(negedge clk);
        pll_ctrl = HOLD_MSK;
        @(negedge clk);
        chk(!c0 && !t0 && !c1 && !t1, "R7 hold next edge", int'(c0 | c1), 0);
        activity(15, a);
        chk(a == 0, "R7 hold stays low", a, 0);
        // R10: release restarts at once
        pll_ctrl = '0;
        @(negedge clk);
        chk(t0 && c0 && t1 && c1, "R10 restart tick", int'(t0 & c0 & t1 & c1), 1);

        // R8: parent clock absent
        repeat (3) @(negedge clk);
        pll_live = 1'b0;
        @(negedge clk);
        chk(!c0 && !t0 && !c1 && !t1, "R8 dead pll next edge", int'(c0 | c1), 0);
        activity(15, a);
        chk(a == 0, "R8 stays low", a, 0);
        pll_live = 1'b1;

        // R9: divisor change mid-period
        measure(0, p, h);
        do @(negedge clk); while (!t0);
        chan_wr = 1'b1;
        chan_wdata = 32'd3;
        cnt = 0;
        do begin
            cnt++;
            @(negedge clk);
            chan_wr = 1'b0;
        end while (!t0 && cnt < 2000);
        chk(cnt == 5, "R9 running period kept", cnt, 5);
        cnt = 0;
        do begin
            cnt++;
            @(negedge clk);
        end while (!t0 && cnt < 2000);
        chk(cnt == 3, "R9 new period at boundary", cnt, 3);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule